// File: doc/BRIEF.md
# Pair-Difference Overload Channel

This block lets a set of extra senders share a code-multiplexed bus that already carries a full orthogonal code set. Each N-chip symbol is divided into N/2 chip pairs, and each pair belongs to one overload lane. An overload sender whose data is 1 adds a single 1 chip on the first chip of its pair. When its data is 0 it adds nothing. The orthogonal codes in use are chosen so that their contribution to the difference between the two bus sums of any pair is always even. The parity of that difference therefore carries the overload lane's bit alone.

The block holds both sides of every overload lane. On the sending side it produces one chip per lane from the lane's data bit and the shared chip counter. This chip goes into the bus adder together with the orthogonal users' chips. On the receiving side it watches the multi-bit bus sum. For each lane it keeps the least significant bit of the sum seen on the first chip of the pair. On the second chip it XORs that kept bit with the new least significant bit, then registers the result and raises a one-cycle valid flag. The bus therefore carries 1.5N users in place of N. The orthogonal users' decoders sit outside this block.

Top module: `pd_overload_channel`

## Requirements
- R1: `enc_chip[l]` is 1 exactly when `pd_data[l]` is 1 and `chip_idx` equals 2l, and is 0 in every other chip. The output is combinational from the current inputs.
- R2: When lane l reports a result, `rx_bit[l]` equals bit 0 of `bus_sum` sampled at the clock edge with `chip_idx` = 2l, XOR bit 0 of `bus_sum` sampled at the next edge with `chip_idx` = 2l+1.
- R3: `rx_valid[l]` is high for exactly the one cycle that follows a clock edge with `chip_idx` = 2l+1, provided the lane is armed. At most one lane's valid is high in any cycle.
- R4: `rx_bit[l]` keeps its value in every cycle in which `rx_valid[l]` is low.
- R5: While `rst_n` is low, `rx_bit` and `rx_valid` are all 0.
- R6: With all N-1 non-constant orthogonal codes active, each lane recovers its sender's data bit in every symbol. Each orthogonal code is the parity of (code index AND chip index), XORed with its user's data bit.
- R7: Bits 1 and up of `bus_sum` have no effect on `rx_bit` or `rx_valid`.
- R8: After reset a lane is armed only once it has captured a sum at chip 2l. A chip 2l+1 seen before that produces no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_idx | input | $clog2(N) | Shared chip counter, advances once per clock |
| pd_data | input | N/2 | Data bit of each overload sender |
| enc_chip | output | N/2 | Chip each overload sender adds to the bus |
| bus_sum | input | SUMW | Sum of all chips on the bus for the current chip |
| rx_bit | output | N/2 | Recovered bit of each overload lane |
| rx_valid | output | N/2 | One-cycle flag marking a fresh `rx_bit` |

## Verification
The bench drives bus sums with random upper bits, so a decoder that compares whole sums rather than only bit 0 produces wrong bits. It also builds full symbols from every orthogonal code with random data. A lane mapped to the wrong pair, or one that captures on the second chip, then returns data that does not match its sender. Reset is released in the middle of a pair, both at start-up and mid-run. A decoder without an arming flag then reports a bit XORed against a stale zero. A valid pulse that is late, repeated or shared across lanes is caught by the per-cycle comparison with the reference model.

// File: rtl/pd_overload_channel.sv
module pd_overload_channel #(
  parameter int N    = 8,
  parameter int SUMW = $clog2(N + N/2 + 1),
  localparam int CW  = $clog2(N),
  localparam int NPD = N / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   chip_idx,
  input  logic [NPD-1:0]  pd_data,
  output logic [NPD-1:0]  enc_chip,
  input  logic [SUMW-1:0] bus_sum,
  output logic [NPD-1:0]  rx_bit,
  output logic [NPD-1:0]  rx_valid
);

  logic [NPD-1:0] first_lsb;
  logic [NPD-1:0] armed;

  for (genvar l = 0; l < NPD; l++) begin : g_lane
    wire at_first  = (chip_idx == CW'(2*l));
    wire at_second = (chip_idx == CW'(2*l + 1));

    assign enc_chip[l] = pd_data[l] & at_first;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_lsb[l] <= 1'b0;
        armed[l]     <= 1'b0;
        rx_bit[l]    <= 1'b0;
        rx_valid[l]  <= 1'b0;
      end else begin
        rx_valid[l] <= at_second & armed[l];
        if (at_first) begin
          first_lsb[l] <= bus_sum[0];
          armed[l]     <= 1'b1;
        end
        if (at_second && armed[l])
          rx_bit[l] <= first_lsb[l] ^ bus_sum[0];
      end
    end
  end

endmodule

// File: rtl/pd_overload_channel_chk.sv
module pd_overload_channel_chk #(
  parameter int N    = 8,
  parameter int SUMW = $clog2(N + N/2 + 1),
  localparam int CW  = $clog2(N),
  localparam int NPD = N / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW-1:0]   chip_idx,
  input logic [NPD-1:0]  pd_data,
  input logic [NPD-1:0]  enc_chip,
  input logic [SUMW-1:0] bus_sum,
  input logic [NPD-1:0]  rx_bit,
  input logic [NPD-1:0]  rx_valid
);

  a_r1_onehot_chips: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enc_chip));

  a_r3_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_valid));

  for (genvar l = 0; l < NPD; l++) begin : g_chk
    a_r3_valid_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[l] |-> $past(chip_idx) == CW'(2*l + 1));

    a_r2_xor_of_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[l] && $past(chip_idx, 2) == CW'(2*l)) |->
        rx_bit[l] == ($past(bus_sum[0]) ^ $past(bus_sum[0], 2)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid[l] |-> $stable(rx_bit[l]));
  end

endmodule

bind pd_overload_channel pd_overload_channel_chk #(.N(N), .SUMW(SUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_idx(chip_idx), .pd_data(pd_data),
  .enc_chip(enc_chip), .bus_sum(bus_sum), .rx_bit(rx_bit), .rx_valid(rx_valid)
);

// File: tb/tb_pd_overload_channel.sv
`timescale 1ns/1ps
module tb_pd_overload_channel;
  localparam int N    = 8;
  localparam int CW   = $clog2(N);
  localparam int NPD  = N / 2;
  localparam int SUMW = $clog2(N + N/2 + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic [CW-1:0]   chip_idx = '0;
  logic [NPD-1:0]  pd_data = '0;
  logic [SUMW-1:0] bus_sum = '0;
  logic [NPD-1:0]  enc_chip, rx_bit, rx_valid;

  always #2.5 clk = ~clk;

  pd_overload_channel #(.N(N), .SUMW(SUMW)) dut (
    .clk(clk), .rst_n(rst_n), .chip_idx(chip_idx), .pd_data(pd_data),
    .enc_chip(enc_chip), .bus_sum(bus_sum), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  bit phase_b = 0;
  logic [NPD-1:0] sym_pd = '0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // reference model
  bit m_hold[NPD], m_armed[NPD];
  logic [NPD-1:0] m_bit = '0, m_valid = '0;
  always @(posedge clk) begin
    for (int l = 0; l < NPD; l++) begin
      if (!rst_n) begin
        m_hold[l] <= 0; m_armed[l] <= 0; m_bit[l] <= 0; m_valid[l] <= 0;
      end else begin
        m_valid[l] <= (int'(chip_idx) == 2*l + 1) && m_armed[l];
        if (int'(chip_idx) == 2*l) begin
          m_hold[l] <= bus_sum % 2;
          m_armed[l] <= 1;
        end
        if (int'(chip_idx) == 2*l + 1 && m_armed[l])
          m_bit[l] <= m_hold[l] ^ (bus_sum % 2);
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    for (int l = 0; l < NPD; l++) begin
      chk("R1 enc_chip", enc_chip[l], (pd_data[l] && int'(chip_idx) == 2*l) ? 1 : 0);
      chk("R3/R8 rx_valid", rx_valid[l], m_valid[l]);
      chk("R2/R4/R7 rx_bit", rx_bit[l], m_bit[l]);
      if (!rst_n) begin
        chk("R5 rx_bit in reset", rx_bit[l], 0);
        chk("R5 rx_valid in reset", rx_valid[l], 0);
      end
      if (phase_b && rx_valid[l])
        chk("R6 recovered data", rx_bit[l], sym_pd[l]);
    end
  end

  function automatic int ortho_sum(int c, logic [N-1:0] od);
    int s = 0;
    for (int r = 1; r < N; r++)
      s += od[r] ^ ($countones(r & c) % 2);
    return s;
  endfunction

  logic [N-1:0] od;
  int c;

  initial begin
    repeat (3) @(negedge clk);
    // R8: release reset on the second chip of pair 0
    chip_idx = 1;
    bus_sum = SUMW'(1);
    rst_n = 1;
    c = 1;
    // Phase A: random sums, R2/R7
    for (int k = 0; k < 40 * N; k++) begin
      @(negedge clk);
      c = (c + 1) % N;
      chip_idx = CW'(c);
      bus_sum = SUMW'($urandom);
      if (c == 0) pd_data = NPD'($urandom);
    end
    // Phase B: full symbols with orthogonal traffic, R6
    for (int s = 0; s < 40; s++) begin
      od = N'($urandom);
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        c = (c + 1) % N;
        if (c == 0) begin
          pd_data = NPD'($urandom);
          sym_pd = pd_data;
          phase_b = (s > 0);
        end
        chip_idx = CW'(c);
        bus_sum = SUMW'(ortho_sum(c, od) +
                  ((c % 2 == 0 && pd_data[c/2]) ? 1 : 0));
      end
    end
    phase_b = 0;
    // Mid-run reset, restart on chip 3 (R5, R8)
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    c = 3;
    chip_idx = CW'(c);
    bus_sum = SUMW'(1);
    rst_n = 1;
    for (int k = 0; k < 4 * N; k++) begin
      @(negedge clk);
      c = (c + 1) % N;
      chip_idx = CW'(c);
      bus_sum = SUMW'($urandom);
      if (c == 0) pd_data = NPD'($urandom);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule